// File: doc/BRIEF.md
# Test Bit Stream Playback Generator

This block plays back a stored one-bit delta-sigma pattern as a test stream. A small internal pattern memory is loaded through a simple write port. Once the generator is enabled, a pattern pointer steps through the memory at a fixed bit rate and wraps after a programmable last index. The bit rate comes from a clock-enable tick that divides the master clock; with the default divider a 32.768 MHz master clock yields 256 kbit/s.

Each emitted bit passes through a tapped shift line. This lets the visible stream lag the pattern by any whole number of bit periods from 0 to 63. A rising edge on an asynchronous sync input is synchronised and turned into a one-cycle modulator sync pulse. When the restart enable is also set, that pulse returns the pointer and the bit-rate divider to zero, so the test signal starts again at a known phase. A loopback select routes the generated stream, instead of the external modulator pin, onto the modulator-data path that feeds the filter.

Top module: `test_stream_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `tbsOut` and `mSyncOut` are low and the pattern pointer is zero.
- R2: While enabled, the stream takes a new bit exactly once every `TICK_DIV` master clocks. After `genEn` rises, the first update follows the `TICK_DIV`-th rising edge. Between updates `tbsOut` holds steady, so each bit is stable for a whole bit period around every master-clock edge.
- R3: With delay 0, the emitted bits are the pattern memory contents read in address order starting at address 0 (memory bit at address i is emitted as bit i).
- R4: After the bit at address `patLast` the pointer wraps to address 0, so the pattern length is `patLast`+1.
- R5: With `delaySel` = d (0 to 63), output bit k equals the delay-0 bit k-d. The first d bits after enabling are 0.
- R6: A rising edge on `syncIn` with `modSyncEn` set gives exactly one high cycle on `mSyncOut`. That cycle is visible after the second rising clock edge following the input edge. With `modSyncEn` clear, no pulse appears.
- R7: When `tsyncEn` is set and a sync pulse occurs while enabled, the pointer and bit divider restart. Address 0 is emitted after the `TICK_DIV`-th rising edge following the edge that ends the pulse. The bits after it follow in address order.
- R8: When `tsyncEn` is clear, a sync pulse leaves the stream phase and contents unchanged.
- R9: While `genEn` is low, `tbsOut` is 0 and the pointer and delay line are cleared. Re-enabling therefore starts again from address 0 with zeroed delay history.
- R10: `modDataOut` equals `tbsOut` when `loopSel` is 1 and equals `extModData` when `loopSel` is 0.
- R11: A write with `memWrEn` high stores `memWrData` at `memWrAddr` on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset |
| genEn | input | 1 | Generator enable |
| syncIn | input | 1 | Asynchronous sync request, rising edge |
| modSyncEn | input | 1 | Enables sync pulse generation |
| tsyncEn | input | 1 | Lets the sync pulse restart the pattern |
| loopSel | input | 1 | 1: route generated stream to modulator-data path |
| patLast | input | PtrW | Last pattern address before wrap |
| delaySel | input | DlyW | Output delay in whole bit periods |
| memWrEn | input | 1 | Pattern memory write strobe |
| memWrAddr | input | PtrW | Pattern memory write address |
| memWrData | input | 1 | Pattern memory write data |
| extModData | input | 1 | External modulator data pin |
| tbsOut | output | 1 | Test bit stream output |
| modDataOut | output | 1 | Selected modulator data toward the filter |
| mSyncOut | output | 1 | One-cycle modulator sync pulse |

## Verification
The bench checks the stream at every master-clock cycle. A design that updated off its tick, or one cycle early or late, would show a bit at the wrong sample or a change between updates. The bench exercises the extreme delays 0 and 63 and a short wrap length. A wrong tap or an uncleared delay line would then give nonzero leading bits or shifted data. Sync is applied mid-pattern with restart enabled, with restart disabled and with pulse generation disabled. A design that ignored either enable would restart when it should not, or continue when it should restart. Disable and re-enable mid-pattern catches a pointer or history that is not cleared.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic bitTick;   // advance one bit this cycle
    logic ptrClear;  // restart pattern at address 0
  } tbsStrobes_t;
endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
#(
  parameter int TICK_DIV = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        genEn,
  input  logic        syncIn,
  input  logic        modSyncEn,
  input  logic        tsyncEn,
  output tbsStrobes_t strobes,
  output logic        mSync
);
  localparam int CntW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(TICK_DIV - 1);

  logic syncMeta, syncSync, syncPrev;
  logic [CntW-1:0] tickCnt;
  logic restart;

  // Two-flop synchroniser followed by an edge detector.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b0;
      syncSync <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncMeta <= syncIn;
      syncSync <= syncMeta;
      syncPrev <= syncSync;
    end
  end

  assign mSync   = syncSync & ~syncPrev & modSyncEn;
  assign restart = mSync & tsyncEn & genEn;

  // Bit-rate divider; held at zero when idle, zeroed on restart.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!genEn || restart || tickCnt == CntLast) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.ptrClear = restart;
    strobes.bitTick  = genEn && !restart && (tickCnt == CntLast);
  end

  // R6: the sync pulse lasts a single cycle.
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    mSync |=> !mSync);

  // R2: ticks are never back to back.
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bitTick |=> !strobes.bitTick);
endmodule

// File: rtl/tbs_datapath.sv
module tbs_datapath
  import tbs_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_DELAY = 63
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                genEn,
  input  tbsStrobes_t                         strobes,
  input  logic [$clog2(DEPTH)-1:0]            patLast,
  input  logic [$clog2(MAX_DELAY+1)-1:0]      delaySel,
  input  logic                                memWrEn,
  input  logic [$clog2(DEPTH)-1:0]            memWrAddr,
  input  logic                                memWrData,
  input  logic                                extModData,
  input  logic                                loopSel,
  output logic                                tbsOut,
  output logic                                modDataOut
);
  localparam int PtrW    = $clog2(DEPTH);
  localparam int DlyW    = $clog2(MAX_DELAY + 1);
  localparam int LineLen = MAX_DELAY + 1;

  logic               patMem [DEPTH];
  logic [PtrW-1:0]    ptr;
  logic [LineLen-1:0] delayLine;
  logic [DlyW-1:0]    tapSel;
  logic               nextBit;

  // Pattern store, preloaded through the write port.
  always_ff @(posedge clk) begin
    if (memWrEn) patMem[memWrAddr] <= memWrData;
  end

  assign nextBit = patMem[ptr];

  // Pattern pointer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (!genEn || strobes.ptrClear) begin
      ptr <= '0;
    end else if (strobes.bitTick) begin
      ptr <= (ptr == patLast) ? '0 : ptr + 1'b1;
    end
  end

  // Whole-bit delay line: stage 0 holds the newest bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayLine <= '0;
    end else if (!genEn) begin
      delayLine <= '0;
    end else if (strobes.bitTick) begin
      delayLine <= {delayLine[LineLen-2:0], nextBit};
    end
  end

  always_comb begin
    if (int'(delaySel) > MAX_DELAY) tapSel = DlyW'(MAX_DELAY);
    else                            tapSel = delaySel;
  end

  assign tbsOut     = genEn & delayLine[tapSel];
  assign modDataOut = loopSel ? tbsOut : extModData;

  // R4: pointer wraps after the last programmed address.
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    genEn && strobes.bitTick && ptr == patLast |=> ptr == '0);

  // R3: pointer steps by one below the last address.
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    genEn && strobes.bitTick && ptr < patLast |=> ptr == $past(ptr) + 1'b1);

  // R7: restart strobe brings the pointer back to address 0.
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    genEn && strobes.ptrClear |=> ptr == '0);

  // R9: idle generator keeps the pointer at zero.
  a_r9_idle_ptr: assert property (@(posedge clk) disable iff (!rstN)
    !genEn |=> ptr == '0);

  // R2: output only moves in the cycle after a tick.
  a_r2_stable: assert property (@(posedge clk) disable iff (!rstN)
    genEn && $past(genEn) && !$past(strobes.bitTick) && delaySel == $past(delaySel)
      |-> tbsOut == $past(tbsOut));
endmodule

// File: rtl/test_stream_gen.sv
module test_stream_gen
  import tbs_pkg::*;
#(
  parameter int TICK_DIV  = 128,
  parameter int DEPTH     = 64,
  parameter int MAX_DELAY = 63,
  localparam int PtrW     = $clog2(DEPTH),
  localparam int DlyW     = $clog2(MAX_DELAY + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            genEn,
  input  logic            syncIn,
  input  logic            modSyncEn,
  input  logic            tsyncEn,
  input  logic            loopSel,
  input  logic [PtrW-1:0] patLast,
  input  logic [DlyW-1:0] delaySel,
  input  logic            memWrEn,
  input  logic [PtrW-1:0] memWrAddr,
  input  logic            memWrData,
  input  logic            extModData,
  output logic            tbsOut,
  output logic            modDataOut,
  output logic            mSyncOut
);
  tbsStrobes_t strobes;

  tbs_ctrl #(.TICK_DIV(TICK_DIV)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .genEn     (genEn),
    .syncIn    (syncIn),
    .modSyncEn (modSyncEn),
    .tsyncEn   (tsyncEn),
    .strobes   (strobes),
    .mSync     (mSyncOut)
  );

  tbs_datapath #(.DEPTH(DEPTH), .MAX_DELAY(MAX_DELAY)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .genEn      (genEn),
    .strobes    (strobes),
    .patLast    (patLast),
    .delaySel   (delaySel),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .extModData (extModData),
    .loopSel    (loopSel),
    .tbsOut     (tbsOut),
    .modDataOut (modDataOut)
  );
endmodule

// File: tb/test_stream_gen_tb_top.sv
module test_stream_gen_tb_top;
  localparam int ClkPeriod = 10;
  localparam int TD   = 4;
  localparam int DEP  = 16;
  localparam int MAXD = 63;
  localparam logic [15:0] PAT = 16'b1011_0011_1000_1101;

  logic clk = 1'b0;
  logic rstN, genEn, syncIn, modSyncEn, tsyncEn, loopSel;
  logic [3:0] patLast;
  logic [5:0] delaySel;
  logic memWrEn, memWrData, extModData;
  logic [3:0] memWrAddr;
  logic tbsOut, modDataOut, mSyncOut;

  int checks = 0, fails = 0;
  int kIdx, base, curLen, curDly;
  logic lastBit;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  test_stream_gen #(.TICK_DIV(TD), .DEPTH(DEP), .MAX_DELAY(MAXD)) dut_i (
    .clk(clk), .rstN(rstN), .genEn(genEn), .syncIn(syncIn),
    .modSyncEn(modSyncEn), .tsyncEn(tsyncEn), .loopSel(loopSel),
    .patLast(patLast), .delaySel(delaySel), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .extModData(extModData),
    .tbsOut(tbsOut), .modDataOut(modDataOut), .mSyncOut(mSyncOut)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic expBit(input int k);
    int idx;
    idx = k - base - curDly;
    if (idx < 0) return 1'b0;
    return PAT[idx % curLen];
  endfunction

  // Wait up to the next update; hold checks first, then the new bit.
  task automatic stepBit(input string req, input int pre);
    logic e;
    for (int i = pre; i < TD; i++) begin
      @(negedge clk);
      if (i < TD - 1) check(tbsOut, lastBit, "R2", "hold between ticks");
      else begin
        e = expBit(kIdx);
        check(tbsOut, e, req, $sformatf("bit %0d", kIdx));
        lastBit = e;
      end
    end
    kIdx++;
  endtask

  task automatic startGen(input int len, input int dly);
    @(negedge clk);
    patLast = 4'(len - 1);
    delaySel = 6'(dly);
    curLen = len; curDly = dly;
    kIdx = 0; base = 0; lastBit = 1'b0;
    genEn = 1'b1;
  endtask

  task automatic stopGen();
    @(negedge clk);
    genEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doSync(input logic expPulse);
    syncIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(mSyncOut, expPulse, "R6", "sync pulse");
    @(negedge clk);
    check(mSyncOut, 1'b0, "R6", "pulse ends after one cycle");
    syncIn = 1'b0;
  endtask

  task automatic testReset();
    rstN = 0; genEn = 0; syncIn = 0; modSyncEn = 0; tsyncEn = 0; loopSel = 0;
    patLast = '0; delaySel = '0; memWrEn = 0; memWrAddr = '0; memWrData = 0; extModData = 0;
    repeat (3) @(negedge clk);
    check(tbsOut, 1'b0, "R1", "tbsOut in reset");
    check(mSyncOut, 1'b0, "R1", "mSyncOut in reset");
    rstN = 1;
    @(negedge clk);
    check(tbsOut, 1'b0, "R1", "tbsOut after reset");
  endtask

  // R11: preload pattern memory.
  task automatic loadPattern();
    for (int i = 0; i < DEP; i++) begin
      @(negedge clk);
      memWrEn = 1'b1; memWrAddr = 4'(i); memWrData = PAT[i];
    end
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic testPlainAndWrap();
    startGen(DEP, 0);
    for (int i = 0; i < 20; i++) stepBit(i < DEP ? "R3" : "R4", 0);
    stopGen();
    startGen(5, 0);
    for (int i = 0; i < 12; i++) stepBit("R4", 0);
    stopGen();
  endtask

  task automatic testDelay(input int dly, input int nBits);
    startGen(DEP, dly);
    for (int i = 0; i < nBits; i++) stepBit("R5", 0);
    stopGen();
  endtask

  task automatic testSyncRestart();
    modSyncEn = 1; tsyncEn = 1;
    startGen(DEP, 0);
    for (int i = 0; i < 6; i++) stepBit("R3", 0);
    doSync(1'b1);
    base = kIdx;
    for (int i = 0; i < 8; i++) stepBit("R7", 0);
    stopGen();
  endtask

  task automatic testSyncIgnored();
    modSyncEn = 1; tsyncEn = 0;
    startGen(DEP, 0);
    for (int i = 0; i < 5; i++) stepBit("R3", 0);
    doSync(1'b1);
    stepBit("R8", 3);
    for (int i = 0; i < 6; i++) stepBit("R8", 0);
    modSyncEn = 0; tsyncEn = 1;
    doSync(1'b0);
    stepBit("R6", 3);
    for (int i = 0; i < 6; i++) stepBit("R6", 0);
    stopGen();
    modSyncEn = 0; tsyncEn = 0;
  endtask

  task automatic testDisable();
    startGen(DEP, 0);
    for (int i = 0; i < 7; i++) stepBit("R3", 0);
    @(negedge clk);
    genEn = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(tbsOut, 1'b0, "R9", "output low while disabled");
    end
    genEn = 1'b1;
    kIdx = 0; base = 0; lastBit = 1'b0;
    for (int i = 0; i < 6; i++) stepBit("R9", 0);
    stopGen();
  endtask

  task automatic testLoopback();
    loopSel = 0;
    extModData = 1; @(negedge clk);
    check(modDataOut, 1'b1, "R10", "external path high");
    extModData = 0; @(negedge clk);
    check(modDataOut, 1'b0, "R10", "external path low");
    loopSel = 1;
    startGen(DEP, 0);
    for (int i = 0; i < 10; i++) begin
      extModData = ~expBit(kIdx);
      stepBit("R10", 0);
      check(modDataOut, lastBit, "R10", "loopback path");
    end
    stopGen();
    loopSel = 0;
  endtask

  initial begin
    testReset();
    loadPattern();
    testPlainAndWrap();
    testDelay(5, 25);
    testDelay(63, 70);
    testSyncRestart();
    testSyncIgnored();
    testDisable();
    testLoopback();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule